// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block gates a group of clock outputs that all come from one reference clock. A stop request is active low. It comes from an external pin or from a register bit held in the clock's own domain, and a select input picks the source. The chosen request is resynchronized into the reference clock domain before the control logic acts on it. Each output has a free-run mask bit. When the bit is set, that output keeps toggling whatever the request does.

Gating happens in a per-output cell. The cell latches its enable while the reference clock is low and ANDs the latched enable with the clock. As a result, a stopped output rests at logic 0, and a restarted output begins with a complete high phase.

A small controller adds an optional delay before the gate closes and an optional delay before it reopens. It also sets a minimum number of enabled cycles after each release, and after reset. A stop request that arrives inside that window waits, and takes effect once the window has run out.

Top module: `clk_stop_gate`

## Requirements
- R1: The request taken into account is `stop_pin_n` when `hw_sel` is 1 and `stop_reg_n` when `hw_sel` is 0. Both are active low (0 means stop). The unselected source has no effect on the outputs.
- R2: An output never shows a high level while `clk` is low. A stopped output is held at 0 for every clock phase.
- R3: An output whose `free_run` bit is 1 follows `clk` in every cycle, whatever the stop request is.
- R4: Take a run window that has expired, and a stop value present before rising edge k. The stoppable outputs still pulse at edges k through k+SYNC_STAGES+OFF_DLY. The first missing high phase is the one after edge k+SYNC_STAGES+OFF_DLY+1.
- R5: Take a release value present before rising edge k while the outputs are stopped. The stoppable outputs stay low through edge k+SYNC_STAGES+ON_DLY. They resume with a full high phase at edge k+SYNC_STAGES+ON_DLY+1. A stop request seen during the reopen delay does not cancel it.
- R6: After the gate reopens, it stays open for exactly MIN_RUN+1 high phases before a stop request that was already pending takes effect. The same window applies after reset.
- R7: During reset and at the first rising edge after it, the controller is in the run state and every output follows `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock driving every output |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stop_pin_n | input | 1 | Asynchronous stop request from a pin, active low |
| stop_reg_n | input | 1 | Stop request from a register bit, active low |
| hw_sel | input | 1 | 1 selects the pin as source, 0 selects the register bit |
| free_run | input | N_OUT | Per-output mask, 1 means never stopped |
| gclk_out | output | N_OUT | Gated clock outputs |

## Verification
The bench uses N_OUT=4, SYNC_STAGES=2, OFF_DLY=0, ON_DLY=2 and MIN_RUN=10. This is the short-window profile with a one-cycle stop and a three-edge restart. With these values a run window expires in a dozen cycles, so random toggling of the pin, the register bit, the select and the mask often sends pending stops, one-cycle releases and restarts cut short through the controller. Directed sequences measure the exact off latency, the on latency and the pulse count of the run window.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_OFF_WAIT = 2'd1,
    ST_HALTED   = 2'd2,
    ST_ON_WAIT  = 2'd3
  } gate_state_e;
endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_n,
  output logic q_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b1;
        else if (s == 0) chain_q[s] <= d_n;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_n = chain_q[STAGES-1];
endmodule

// File: rtl/stop_ctrl.sv
module stop_ctrl
  import clkstop_pkg::*;
#(
  parameter int MIN_RUN = 10,
  parameter int OFF_DLY = 0,
  parameter int ON_DLY  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_act,
  output logic gate_off
);
  localparam int MAXV = (MIN_RUN > OFF_DLY) ? ((MIN_RUN > ON_DLY) ? MIN_RUN : ON_DLY)
                                            : ((OFF_DLY > ON_DLY) ? OFF_DLY : ON_DLY);
  localparam int CW = $clog2(MAXV + 1) + 1;

  gate_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: begin
        if (stop_act && cnt_q == CW'(MIN_RUN)) begin
          state_d = (OFF_DLY == 0) ? ST_HALTED : ST_OFF_WAIT;
          cnt_d   = '0;
        end else if (cnt_q < CW'(MIN_RUN)) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_OFF_WAIT: begin
        if (cnt_q == CW'(OFF_DLY - 1)) state_d = ST_HALTED;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_HALTED: begin
        if (!stop_act) begin
          state_d = (ON_DLY == 0) ? ST_RUN : ST_ON_WAIT;
          cnt_d   = '0;
        end
      end
      ST_ON_WAIT: begin
        if (cnt_q == CW'(ON_DLY - 1)) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gate_off = (state_q == ST_HALTED) || (state_q == ST_ON_WAIT);

  // Independent open-window counter used only by the checks below
  logic [CW-1:0] chk_open_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_open_q <= '0;
    else if (gate_off) chk_open_q <= '0;
    else if (chk_open_q < CW'(MIN_RUN)) chk_open_q <= chk_open_q + 1'b1;
  end

  p_min_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_off) |-> (chk_open_q >= CW'(MIN_RUN)));

  p_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && stop_act && chk_open_q == CW'(MIN_RUN)) |=> (state_q != ST_RUN));
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic keep_run,
  input  logic gate_off,
  output logic gclk
);
  logic en_lat;

  always_latch begin
    if (!clk) en_lat = keep_run | ~gate_off;
  end

  assign gclk = clk & en_lat;

  p_free_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    keep_run |-> en_lat);

  p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off && !keep_run) |-> !en_lat);
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int OFF_DLY     = 0,
  parameter int ON_DLY      = 2,
  parameter int MIN_RUN     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_pin_n,
  input  logic             stop_reg_n,
  input  logic             hw_sel,
  input  logic [N_OUT-1:0] free_run,
  output logic [N_OUT-1:0] gclk_out
);
  logic req_raw_n;
  logic req_sync_n;
  logic gate_off;

  // Source choice ahead of the synchronizer keeps one latency for both (R1)
  assign req_raw_n = hw_sel ? stop_pin_n : stop_reg_n;

  stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_n  (req_raw_n),
    .q_n  (req_sync_n)
  );

  stop_ctrl #(.MIN_RUN(MIN_RUN), .OFF_DLY(OFF_DLY), .ON_DLY(ON_DLY)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop_act(~req_sync_n),
    .gate_off(gate_off)
  );

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      clk_gate_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .keep_run(free_run[i]),
        .gate_off(gate_off),
        .gclk    (gclk_out[i])
      );
    end
  endgenerate
endmodule

// File: tb/sim_clk_stop_gate.sv
module sim_clk_stop_gate;
  localparam int N = 4, SYNC = 2, OFFD = 0, OND = 2, MINR = 10;

  logic clk = 1'b0, rst_n = 1'b0, pin_n = 1'b1, reg_n = 1'b1, hw_sel = 1'b1;
  logic [N-1:0] fr = '0;
  logic [N-1:0] gout;
  int total = 0, bad = 0;
  bit live = 0;

  clk_stop_gate #(.N_OUT(N), .SYNC_STAGES(SYNC), .OFF_DLY(OFFD), .ON_DLY(OND),
                  .MIN_RUN(MINR)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_pin_n(pin_n), .stop_reg_n(reg_n),
    .hw_sel(hw_sel), .free_run(fr), .gclk_out(gout));

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Reference model of the request path and the open/closed decision
  logic [SYNC-1:0] m_pipe;
  int m_st, m_cnt;
  bit m_on;

  always @(posedge clk) begin
    logic [N-1:0] e;
    bit act;
    if (!rst_n) begin
      m_pipe = '1; m_st = 0; m_cnt = 0; m_on = 1;
    end else begin
      e   = fr | {N{m_on}};
      act = !m_pipe[SYNC-1];
      m_pipe = {m_pipe[SYNC-2:0], (hw_sel ? pin_n : reg_n)};
      case (m_st)
        0: if (act && m_cnt == MINR) begin m_st = (OFFD == 0) ? 2 : 1; m_cnt = 0; end
           else if (m_cnt < MINR) m_cnt++;
        1: if (m_cnt == OFFD - 1) m_st = 2; else m_cnt++;
        2: if (!act) begin m_st = (OND == 0) ? 0 : 3; m_cnt = 0; end
        default: if (m_cnt == OND - 1) begin m_st = 0; m_cnt = 0; end else m_cnt++;
      endcase
      m_on = (m_st == 0 || m_st == 1);
      #2;
      if (live)
        for (int i = 0; i < N; i++)
          chk(fr[i] ? "R3" : (e[i] ? "R6" : "R4"), 4'(gout[i]), 4'(e[i]));
    end
  end

  always @(negedge clk) begin
    #2;
    if (live) chk("R2", gout, '0);
  end

  task automatic count_run(input logic lvl, output int n);
    n = 0;
    forever begin
      @(posedge clk); #2;
      if (gout[0] == lvl) n++;
      else break;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, n1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R7", gout, '1);
    live = 1;
    repeat (15) @(negedge clk);

    // R1: unselected pin asserted, register source idle
    hw_sel = 1'b0; pin_n = 1'b0;
    repeat (20) @(negedge clk);
    @(posedge clk); #2;
    chk("R1", gout, '1);

    // R4: switch to the asserted pin with an expired window
    @(negedge clk);
    hw_sel = 1'b1;
    count_run(1'b1, n);
    chk_int("R4", n, SYNC + OFFD + 1);
    repeat (10) @(posedge clk); #2;
    chk("R4", gout, '0);

    // R3: masked outputs keep running while stopped
    @(negedge clk); fr = 4'b0101;
    @(posedge clk); #2;
    chk("R3", gout, 4'b0101);
    @(negedge clk); fr = '0;

    // R5 and R6: one-edge release, then a stop pending through the window
    repeat (3) @(negedge clk);
    pin_n = 1'b1;
    fork begin @(negedge clk); pin_n = 1'b0; end join_none
    count_run(1'b0, n);
    chk_int("R5", n, SYNC + OND + 1);
    count_run(1'b1, n1);
    chk_int("R6", n1 + 1, MINR + 1);

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ($urandom_range(7) == 0)  pin_n  = ~pin_n;
      if ($urandom_range(15) == 0) reg_n  = ~reg_n;
      if ($urandom_range(63) == 0) hw_sel = ~hw_sel;
      if ($urandom_range(31) == 0) fr     = N'($urandom);
    end
    @(posedge clk); #3;
    live = 0;
    finish_run();
  end
endmodule